// File: doc/BRIEF.md
# System Clock Control Unit

This block produces the system clock enable of a small 4-bit microcontroller. Two free-running tick inputs stand for the main and sub oscillators. Each is a one-cycle pulse in the core clock domain. A 4-bit control register picks the source and can stop the main oscillator. It also sets a power-of-two prescaler that passes one pulse out of every 1, 2, 4 or 8 ticks of the chosen source. The CPU writes the register from its accumulator through a strobe and a data bus, and reads it back on a separate bus.

A write that would stop the main oscillator while the main source is selected is refused, so the system clock is never starved. A change of source waits for the end of the current prescaler period. A change of ratio restarts the prescaler. A power-down request is granted only when the main clock is not an external clock. While power-down is granted, the prescaler freezes and the register keeps its value.

Top module: `sysclk_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the read-back bus shows 4'b1100: ratio field 11, main oscillator running, main source selected.
- R2: A write is accepted unless R3 rejects it. An accepted write is visible on the read-back bus in the next cycle. Bits [3:2] hold the ratio code, bit 1 stops the main oscillator when 1, and bit 0 selects the sub source when 1.
- R3: A write whose data has bit 1 = 1 and bit 0 = 0 is ignored, and the register keeps its previous value.
- R4: Ratio codes 00, 01, 10 and 11 make sys_en pulse, in the same cycle, on every 1st, 2nd, 4th or 8th counted tick of the active source.
- R5: An accepted write that changes bits [3:2] restarts the period count. The next pulse needs a full period at the new ratio, counting from the tick after the write cycle. A tick in the write cycle still pulses if it ends the old period.
- R6: The active source takes the value of bit 0 only in a cycle that ends a period (sys_en high). The next cycle counts ticks of the new source.
- R7: main_osc_en is low only when bit 1 is 1 and the sub source is already active.
- R8: pd_grant equals pd_req when ext_clk_sel is low, and pd_blocked equals pd_req when ext_clk_sel is high. While pd_grant is high, no tick is counted and sys_en stays low.
- R9: A granted power-down leaves the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_tick | input | 1 | One-cycle pulse per main oscillator period |
| sub_tick | input | 1 | One-cycle pulse per sub oscillator period |
| ext_clk_sel | input | 1 | High when the main clock comes from an external source |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Value written from the accumulator |
| rd_data | output | 4 | Current register contents |
| pd_req | input | 1 | Power-down request |
| pd_grant | output | 1 | Power-down accepted |
| pd_blocked | output | 1 | Power-down refused because the external clock is selected |
| main_osc_en | output | 1 | Run control for the main oscillator |
| sys_en | output | 1 | System clock enable pulse |

## Verification
Several properties are checked on every cycle: the forbidden stop-while-main combination never sits in the register, the period counter never passes its limit, a source change happens only after a period end, and a granted power-down freezes the counter and silences sys_en. Other behaviour can only be shown by the bench's scenarios: the exact spacing of pulses at each ratio, the full new period after a ratio change, and the register keeping its value across power-down. The bench runs these directed cases, then mixes random writes, ticks and requests against a cycle-level model.

// File: rtl/sysclk_pkg.sv
// Shared types and sizes for the system clock control unit.
package sysclk_pkg;
    localparam int CFG_W   = 4;            // control register width
    localparam int RATIO_W = 2;            // ratio code width
    localparam int CNT_W   = 2**RATIO_W - 1; // counter width for largest ratio
    localparam logic [CFG_W-1:0] CFG_RESET = 4'b1100;

    typedef enum logic {SRC_MAIN = 1'b0, SRC_SUB = 1'b1} src_e;

    // Last count value of a period for a given ratio code.
    function automatic logic [CNT_W-1:0] period_limit(input logic [RATIO_W-1:0] code);
        return CNT_W'((1 << code) - 1);
    endfunction
endpackage

// File: rtl/sysclk_cfg_reg.sv
// Control register with write filter.
// Assumes wr_data is valid in the cycle wr_en is high. Rejects any value
// that stops the main oscillator while selecting the main source, and
// flags accepted writes that change the ratio field.
module sysclk_cfg_reg
    import sysclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg,
    output logic             ratio_chg
);
    logic accept;

    // Decide whether this write may be applied.
    always_comb begin
        accept    = wr_en && !(wr_data[1] && !wr_data[0]);
        ratio_chg = accept && (wr_data[CFG_W-1:CFG_W-RATIO_W] != cfg[CFG_W-1:CFG_W-RATIO_W]);
    end

    // Hold the register, loading accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= CFG_RESET;
        else if (accept) cfg <= wr_data;
    end

    AST_RESET_VALUE: assert property (@(posedge clk) !rst_n |=> cfg == CFG_RESET); // R1
    AST_NO_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg[1] && !cfg[0])); // R3
endmodule

// File: rtl/sysclk_src_sel.sv
// Source selection and main oscillator control.
// Assumes period_end marks the last counted tick of a period. The active
// source follows the requested one only at such a boundary. The main
// oscillator stops only once the sub source is active.
module sysclk_src_sel
    import sysclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_sub,
    input  logic stop_main,
    input  logic main_tick,
    input  logic sub_tick,
    input  logic freeze,
    input  logic period_end,
    output logic tick,
    output logic main_osc_en
);
    src_e src_act;

    // Gate and steer the tick of the active source.
    always_comb begin
        main_osc_en = !(stop_main && src_act == SRC_SUB);
        if (freeze)                tick = 1'b0;
        else if (src_act == SRC_SUB) tick = sub_tick;
        else                       tick = main_tick && main_osc_en;
    end

    // Move to the requested source at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          src_act <= SRC_MAIN;
        else if (period_end) src_act <= sel_sub ? SRC_SUB : SRC_MAIN;
    end

    AST_SWITCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_act) |-> $past(period_end)); // R6
    AST_OSC_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !main_osc_en |-> src_act == SRC_SUB); // R7
endmodule

// File: rtl/sysclk_prescaler.sv
// Power-of-two period counter.
// Counts incoming ticks and marks the last tick of each period. An
// accepted ratio change restarts the count from zero.
module sysclk_prescaler
    import sysclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               restart,
    input  logic               freeze,
    input  logic [RATIO_W-1:0] ratio,
    output logic               period_end
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Find the period limit and flag its final tick.
    always_comb begin
        limit      = period_limit(ratio);
        period_end = tick && (cnt == limit);
    end

    // Advance, wrap or restart the period count.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (restart)    cnt <= '0;
        else if (period_end) cnt <= '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit); // R4
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !restart) |=> $stable(cnt)); // R8
    AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> !period_end); // R8
endmodule

// File: rtl/sysclk_ctrl.sv
// System clock control unit top.
// Wires the control register, the source selector and the prescaler.
// It also grants or blocks power-down depending on the external clock mode.
module sysclk_ctrl
    import sysclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_tick,
    input  logic             sub_tick,
    input  logic             ext_clk_sel,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    input  logic             pd_req,
    output logic             pd_grant,
    output logic             pd_blocked,
    output logic             main_osc_en,
    output logic             sys_en
);
    logic [CFG_W-1:0] cfg;
    logic             ratio_chg;
    logic             tick;
    logic             period_end;

    // Power-down arbitration against the external clock mode.
    always_comb begin
        pd_grant   = pd_req && !ext_clk_sel;
        pd_blocked = pd_req && ext_clk_sel;
        rd_data    = cfg;
        sys_en     = period_end;
    end

    sysclk_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg(cfg), .ratio_chg(ratio_chg)
    );

    sysclk_src_sel u_src (
        .clk(clk), .rst_n(rst_n), .sel_sub(cfg[0]), .stop_main(cfg[1]),
        .main_tick(main_tick), .sub_tick(sub_tick), .freeze(pd_grant),
        .period_end(period_end), .tick(tick), .main_osc_en(main_osc_en)
    );

    sysclk_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(ratio_chg),
        .freeze(pd_grant), .ratio(cfg[CFG_W-1:CFG_W-RATIO_W]),
        .period_end(period_end)
    );

    AST_PD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pd_grant && pd_blocked)); // R8
    AST_PD_RETAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_grant && !wr_en) |=> $stable(rd_data)); // R9
endmodule

// File: tb/tb_sysclk_ctrl.sv
module tb_sysclk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_tick = 0, sub_tick = 0, ext_clk_sel = 0, wr_en = 0, pd_req = 0;
    logic [3:0] wr_data = 0;
    logic [3:0] rd_data;
    logic       pd_grant, pd_blocked, main_osc_en, sys_en;

    int total = 0, bad = 0;
    logic [3:0] m_cfg;
    logic       m_src;
    logic [2:0] m_cnt;

    always #5 clk = ~clk;

    sysclk_ctrl dut (.*);

    function automatic logic [2:0] lim_of(input logic [1:0] c);
        return 3'((1 << c) - 1);
    endfunction

    function automatic logic exp_run(input logic [3:0] c, input logic s);
        return !(c[1] && s);
    endfunction

    function automatic logic exp_tick(input logic [3:0] c, input logic s,
                                      input logic mt, input logic st, input logic g);
        if (g) return 1'b0;
        return s ? st : (mt && exp_run(c, s));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle, compare all outputs, then advance the model.
    task automatic step(input logic w, input logic [3:0] d, input logic mt,
                        input logic st, input logic pd, input logic ex);
        logic g, t, e, acc;
        wr_en = w; wr_data = d; main_tick = mt; sub_tick = st; pd_req = pd; ext_clk_sel = ex;
        @(negedge clk);
        g = pd && !ex;
        t = exp_tick(m_cfg, m_src, mt, st, g);
        e = t && (m_cnt == lim_of(m_cfg[3:2]));
        check("R4 sys_en", sys_en, e);
        check("R2 rd_data", rd_data, m_cfg);
        check("R7 main_osc_en", main_osc_en, exp_run(m_cfg, m_src));
        check("R8 pd_grant", pd_grant, g);
        check("R8 pd_blocked", pd_blocked, pd && ex);
        @(posedge clk);
        acc = w && !(d[1] && !d[0]);
        if (acc && d[3:2] != m_cfg[3:2]) m_cnt = 0;
        else if (e) m_cnt = 0;
        else if (t) m_cnt = m_cnt + 1;
        if (e) m_src = m_cfg[0];
        if (acc) m_cfg = d;
        #1;
    endtask

    initial begin
        #200000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_cfg = 4'b1100; m_src = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check("R1 reset rd_data", rd_data, 4'b1100);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 value after release
        check("R1 after release", rd_data, 4'b1100);
        // R4 divide by 8 on main
        for (int i = 0; i < 20; i++) step(0, 0, 1, 0, 0, 0);
        // R2 write ratio 01 (R5 restart)
        step(1, 4'b0100, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 0, 0);
        // R3 rejected write: stop with main selected
        step(1, 4'b0010, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        check("R3 reject kept", rd_data, 4'b0100);
        // R5 change ratio in mid period
        step(1, 4'b1000, 1, 0, 0, 0);
        step(1, 4'b1100, 1, 0, 0, 0);
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 0, 0);
        // R6 switch to sub with stop, only sub ticks afterwards
        step(1, 4'b0011, 1, 1, 0, 0);
        for (int i = 0; i < 12; i++) step(0, 0, i % 2, (i % 3) == 0, 0, 0);
        // R9 power-down retention, R8 freeze
        for (int i = 0; i < 6; i++) step(0, 0, 1, 1, 1, 0);
        check("R9 retained", rd_data, 4'b0011);
        // R8 blocked with external clock
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, 1);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 6) == 0, 4'($urandom), $urandom % 2, $urandom % 2,
                 ($urandom % 5) == 0, ($urandom % 3) == 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule